// File: doc/BRIEF.md
# Page Residency Counter Table

This block sits beside one cache in a multi-cache system where main memory keeps a single presence bit per page per cache, not one per block. Such a bit says that at least one block of the page has been copied into this cache. The bit may only be cleared once no block of that page remains in the cache. The block tracks this with a small associative table. Each entry holds a page number and a count of the blocks from that page that are currently resident.

The cache reports two kinds of event. A fill is a block READ it issues to memory. A drop is a block leaving the cache, either through replacement or through a successful EXCLUDE. A fill to a tracked page adds one to that page's count. A fill to an untracked page claims a free entry with a count of one. A drop subtracts one. When a drop takes a count to zero, the entry is released. In that same cycle `eject_o` tells the cache to turn its outgoing write into a write-and-eject, so that memory clears the page presence bit. If the table is full and a fill arrives for an untracked page, the block raises `stall_o` and the fill is not recorded. The cache must hold off and retry that fill.

Top module: `page_tally`

## Requirements
- R1: After reset the table is empty. With both event inputs low, `stall_o` and `eject_o` are 0, and a drop to any page then gives `eject_o` = 0.
- R2: A fill (`fill_vld_i`=1) to a page with no entry, while an entry is free, creates an entry for that page with a count of 1. A single later drop of that page raises `eject_o`.
- R3: A fill to a page that already has an entry raises its count by exactly one. After N fills, the page needs N drops, and only the Nth drop raises `eject_o`.
- R4: A drop (`drop_vld_i`=1) to a tracked page lowers its count by one. `eject_o` is 1, combinationally in the same cycle, exactly when that drop takes the count from 1 to 0. In that case the entry is freed at the next clock edge.
- R5: `eject_o` is 0 in every other cycle, including a drop that leaves a count above zero.
- R6: A fill and a drop to the same tracked page in the same cycle cancel out. The count is unchanged and `eject_o` stays 0.
- R7: A drop to a page with no entry is ignored. `eject_o` stays 0 and no count changes.
- R8: `stall_o` is 1, combinationally, exactly when a fill targets an untracked page while all ENTRIES entries are occupied at the start of the cycle. That fill is discarded and the page stays untracked.
- R9: An entry freed by a final drop can be claimed again. After it is freed, a fill to a new page no longer stalls.
- R10: A count reaches LINES, the number of cache lines, without wrapping. LINES fills need LINES drops before `eject_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fill_vld_i | input | 1 | The cache issues a block READ this cycle |
| fill_page_i | input | PAGE_W | Page number of the block being read |
| drop_vld_i | input | 1 | A block leaves the cache (replacement or successful EXCLUDE) |
| drop_page_i | input | PAGE_W | Page number of the departing block |
| stall_o | output | 1 | Table full and fill to an untracked page; the fill was not recorded |
| eject_o | output | 1 | This drop removed the page's last block; send write-and-eject |

## Verification
All internal state shows at the ports only through `eject_o` and `stall_o`, and the reference model compares both every cycle.

If a count is one too high, the page's final drop shows `eject_o` low where the model expects high. If a count is one too low, `eject_o` rises one drop early. Either error appears in the cycle of the drop concerned.

If an entry leaks or is lost, `stall_o` is wrong on the next fill to an untracked page once the table nears full. Directed sequences drive this case deliberately.

// File: rtl/page_tally_pkg.sv
package page_tally_pkg;

  localparam int PT_ENTRIES = 4;
  localparam int PT_PAGE_W  = 8;
  localparam int PT_LINES   = 16;

  // Bits needed to hold any count from 0 to lines inclusive.
  function automatic int cnt_width(input int lines);
    return (lines < 1) ? 1 : $clog2(lines + 1);
  endfunction

endpackage

// File: rtl/page_match.sv
module page_match #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 8
) (
  input  logic [ENTRIES-1:0]        valid_i,
  input  logic [ENTRIES*PAGE_W-1:0] tab_i,
  input  logic [PAGE_W-1:0]         key_i,
  output logic [ENTRIES-1:0]        hit_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tab_i[g*PAGE_W +: PAGE_W] == key_i);
  end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0] valid_i,
  output logic [ENTRIES-1:0] grant_o
);

  logic taken;

  always_comb begin
    grant_o = '0;
    taken   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !taken) begin
        grant_o[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/count_slot.sv
module count_slot #(
  parameter int PAGE_W = 8,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              valid_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [CW-1:0]     cnt_o,
  output logic              last_o
);

  logic              valid_q, valid_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              en;

  // Final block of the page leaves, with no fill of the same page to offset it.
  assign last_o = dec_i && !inc_i && (cnt_q == CW'(1));
  assign en     = alloc_i || (inc_i ^ dec_i);

  always_comb begin
    valid_d = valid_q;
    page_d  = page_q;
    cnt_d   = cnt_q;
    if (alloc_i) begin
      valid_d = 1'b1;
      page_d  = page_i;
      cnt_d   = CW'(1);
    end else if (inc_i && !dec_i) begin
      cnt_d = cnt_q + CW'(1);
    end else if (dec_i && !inc_i) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
      cnt_q   <= '0;
    end else if (en) begin
      valid_q <= valid_d;
      page_q  <= page_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid_o = valid_q;
  assign page_o  = page_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/page_tally.sv
module page_tally
  import page_tally_pkg::*;
#(
  parameter int ENTRIES = PT_ENTRIES,
  parameter int PAGE_W  = PT_PAGE_W,
  parameter int LINES   = PT_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_vld_i,
  input  logic [PAGE_W-1:0] fill_page_i,
  input  logic              drop_vld_i,
  input  logic [PAGE_W-1:0] drop_page_i,
  output logic              stall_o,
  output logic              eject_o
);

  localparam int CW = cnt_width(LINES);

  logic [ENTRIES-1:0]        valid_q, fill_hit, drop_hit, free_pick;
  logic [ENTRIES-1:0]        alloc_v, inc_v, dec_v, last_v;
  logic [ENTRIES*PAGE_W-1:0] page_flat;
  logic [ENTRIES*CW-1:0]     cnt_flat;
  logic                      fill_known, table_full, alloc_ok;

  page_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_fill_match (
    .valid_i(valid_q), .tab_i(page_flat), .key_i(fill_page_i), .hit_o(fill_hit)
  );

  page_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_drop_match (
    .valid_i(valid_q), .tab_i(page_flat), .key_i(drop_page_i), .hit_o(drop_hit)
  );

  slot_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .valid_i(valid_q), .grant_o(free_pick)
  );

  always_comb begin
    fill_known = |fill_hit;
    table_full = &valid_q;
    alloc_ok   = fill_vld_i && !fill_known && !table_full;
    stall_o    = fill_vld_i && !fill_known && table_full;
    alloc_v    = {ENTRIES{alloc_ok}} & free_pick;
    inc_v      = {ENTRIES{fill_vld_i}} & fill_hit;
    dec_v      = {ENTRIES{drop_vld_i}} & drop_hit;
    eject_o    = |last_v;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    count_slot #(.PAGE_W(PAGE_W), .CW(CW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (alloc_v[g]),
      .inc_i   (inc_v[g]),
      .dec_i   (dec_v[g]),
      .page_i  (fill_page_i),
      .valid_o (valid_q[g]),
      .page_o  (page_flat[g*PAGE_W +: PAGE_W]),
      .cnt_o   (cnt_flat[g*CW +: CW]),
      .last_o  (last_v[g])
    );
  end

endmodule

// File: rtl/page_tally_chk.sv
module page_tally_chk #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 8,
  parameter int LINES   = 16,
  parameter int CW      = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fill_vld_i,
  input logic [PAGE_W-1:0]       fill_page_i,
  input logic                    drop_vld_i,
  input logic [PAGE_W-1:0]       drop_page_i,
  input logic                    stall_o,
  input logic                    eject_o,
  input logic [ENTRIES-1:0]      valid_q,
  input logic [ENTRIES-1:0]      fill_hit,
  input logic [ENTRIES*CW-1:0]   cnt_flat
);

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit)); // R2

  AST_EJECT_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eject_o |-> drop_vld_i); // R5

  AST_EJECT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (eject_o && !fill_vld_i) |=> ($countones(valid_q) == $past($countones(valid_q)) - 1)); // R4

  AST_STALL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !drop_vld_i) |=> $stable(valid_q)); // R8

  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld_i && drop_vld_i && (fill_page_i == drop_page_i) && (|fill_hit))
      |=> $stable(cnt_flat)); // R6

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ovf
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[g*CW +: CW] <= CW'(LINES)); // R10
  end

endmodule

bind page_tally page_tally_chk #(
  .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .LINES(LINES), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fill_vld_i(fill_vld_i), .fill_page_i(fill_page_i),
  .drop_vld_i(drop_vld_i), .drop_page_i(drop_page_i),
  .stall_o(stall_o), .eject_o(eject_o),
  .valid_q(valid_q), .fill_hit(fill_hit), .cnt_flat(cnt_flat)
);

// File: tb/sim_page_tally.sv
module sim_page_tally;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 4;
  localparam int PAGE_W     = 8;
  localparam int LINES      = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fill_vld = 1'b0;
  logic [PAGE_W-1:0] fill_page = '0;
  logic              drop_vld = 1'b0;
  logic [PAGE_W-1:0] drop_page = '0;
  logic              stall_o, eject_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int model [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_tally #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fill_vld_i(fill_vld), .fill_page_i(fill_page),
    .drop_vld_i(drop_vld), .drop_page_i(drop_page),
    .stall_o(stall_o), .eject_o(eject_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle, compare the outputs against the model, then advance the model.
  task automatic step(input string tag, input bit fv, input int fp, input bit dv, input int dp);
    bit fh, dh, same, xs, xe;
    @(negedge clk);
    fill_vld  = fv;
    fill_page = PAGE_W'(fp);
    drop_vld  = dv;
    drop_page = PAGE_W'(dp);
    fh   = model.exists(fp);
    dh   = model.exists(dp);
    same = fv && dv && (fp == dp);
    xs   = fv && !fh && (model.num() == ENTRIES);
    xe   = 1'b0;
    if (dv && dh && !same) xe = (model[dp] == 1);
    #1;
    check(tag, "stall_o", stall_o, xs);
    check(tag, "eject_o", eject_o, xe);
    @(posedge clk);
    if (!(same && fh)) begin
      if (dv && dh) begin
        model[dp] = model[dp] - 1;
        if (model[dp] == 0) model.delete(dp);
      end
      if (fv) begin
        if (fh) model[fp] = model[fp] + 1;
        else if (!xs) model[fp] = 1;
      end
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "stall_o in reset", stall_o, 1'b0);
    check("R1", "eject_o in reset", eject_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table after reset.
    step("R1", 0, 0, 0, 0);
    step("R1", 0, 0, 1, 5);

    // R2: a new page gets a count of one.
    step("R2", 1, 3, 0, 0);
    step("R2", 0, 0, 1, 3);

    // R3 and R5: three fills need three drops.
    for (int i = 0; i < 3; i++) step("R3", 1, 7, 0, 0);
    step("R5", 0, 0, 1, 7);
    step("R5", 0, 0, 1, 7);
    step("R4", 0, 0, 1, 7);

    // R6: a fill and a drop to the same page in one cycle cancel.
    step("R6", 1, 9, 0, 0);
    step("R6", 1, 9, 1, 9);
    step("R6", 1, 9, 1, 9);
    step("R4", 0, 0, 1, 9);

    // R7: a drop to an untracked page changes nothing.
    step("R7", 1, 11, 0, 0);
    step("R7", 0, 0, 1, 12);
    step("R7", 0, 0, 1, 11);

    // R8: the table is full, so a fill to a new page stalls and is dropped.
    for (int p = 1; p <= ENTRIES; p++) step("R8", 1, p, 0, 0);
    step("R8", 1, 40, 0, 0);
    step("R8", 0, 0, 1, 40);
    step("R8", 1, 41, 1, 2);

    // R9: a freed entry is claimed again.
    step("R9", 0, 0, 1, 1);
    step("R9", 1, 41, 0, 0);
    step("R9", 1, 42, 0, 0);
    step("R9", 0, 0, 1, 41);
    step("R9", 0, 0, 1, 3);
    step("R9", 0, 0, 1, 4);

    // R10: a count reaches LINES without wrapping.
    for (int i = 0; i < LINES; i++) step("R10", 1, 32, 0, 0);
    for (int i = 0; i < LINES; i++) step("R10", 0, 0, 1, 32);

    // Mixed traffic over a small page set.
    for (int i = 0; i < 600; i++) begin
      bit fv, dv;
      int fp, dp;
      fv = 1'($urandom_range(0, 1));
      dv = 1'($urandom_range(0, 1));
      fp = int'($urandom_range(0, 6));
      dp = int'($urandom_range(0, 6));
      if (model.exists(fp) && model[fp] >= LINES) fv = 1'b0;
      step("R4", fv, fp, dv, dp);
    end

    step("R5", 0, 0, 0, 0);
    done = 1'b1;
    finish_run();
  end

endmodule